// File: doc/BRIEF.md
# Turn-Stacking Bucket Accumulator

The block takes one 12-bit unsigned ADC sample on every bunch clock and files it under the bucket position that sample belongs to. A pulse from the timing system marks bucket 0 of each turn. For every bucket the block keeps a result word that holds two values: a running sum of the samples from many turns, and a count of the samples that were strictly greater than a programmable threshold. Accumulation runs on a fixed schedule. A new buffer starts every `cfg_buf_period` turns and collects `cfg_turns_per_buf` turns. The turns between the end of one buffer and the start of the next are not stored.

There are two storage banks, used ping-pong. One bank accumulates while the host reads the finished bank through a synchronous address/data port, so no turn is lost to readout. A buffer finishes at the bunch-zero pulse that follows its last turn. At that pulse the banks swap and a ready flag rises. The flag stays high until the host acknowledges it. The first turn of every buffer writes fresh values over the stale contents of a bucket, so the block never needs a clearing pass. A sticky error flag records a bunch-zero pulse that arrives before the programmed number of buckets has elapsed. All configuration inputs are expected to stay constant while the block is running.

Top module: `turn_stack_acc`

## Requirements
- R1: After reset, `buf_ready` and `sync_err` are 0.
- R2: The sample taken with `bunch_zero` high goes to bucket 0, and each later sample goes to the next bucket. Across the turns of one buffer, a bucket word read back holds the sum of its samples in bits [35:12] and its hit count in bits [11:0].
- R3: A sample counts as a hit only if it is strictly greater than `cfg_threshold`. A sample equal to the threshold is not a hit.
- R4: On the first turn of a buffer, each bucket word is replaced by that turn's sample and hit bit. Contents left over from earlier buffers do not leak into the new result.
- R5: A buffer finishes at the `bunch_zero` pulse that follows its last accumulating turn. `buf_ready` rises two clock edges after that pulse, and the read port then returns the finished bank. `rd_data` reflects `rd_addr` two clock edges after the address is applied.
- R6: `buf_ready` stays high until a one-cycle `rdy_ack`, which clears it.
- R7: With `cfg_buf_period` = P and `cfg_turns_per_buf` = N (P ≥ N), only turns 0..N-1 of every P-turn period are accumulated. Samples taken in turns N..P-1 change no bank and cause no swap.
- R8: A `bunch_zero` pulse that arrives when fewer than `cfg_turn_len` samples have followed the previous pulse sets `sync_err`. The flag stays set until reset, and that pulse still restarts the count at bucket 0.
- R9: Samples that arrive after bucket `cfg_turn_len`-1 and before the next `bunch_zero` are discarded. A late pulse does not set `sync_err`.
- R10: Back-to-back updates of the same bucket accumulate correctly. For example, with `cfg_turn_len` = 1, every sample adds to bucket 0.
- R11: The sum saturates at 2^24-1 and the hit count saturates at 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_sample | input | 12 | Unsigned ADC reading, one per clock |
| bunch_zero | input | 1 | High with the sample of bucket 0 |
| cfg_threshold | input | 12 | Hit threshold (a hit is a sample strictly greater than this value) |
| cfg_turn_len | input | 13 | Buckets per turn, 1..4096 |
| cfg_turns_per_buf | input | 13 | Turns accumulated per buffer, N ≥ 1 |
| cfg_buf_period | input | 13 | Turns between buffer starts; a value below N is treated as N |
| rd_addr | input | 12 | Host read address (bucket index) |
| rd_data | output | 36 | Finished-bank word: sum in [35:12], count in [11:0] |
| buf_ready | output | 1 | A finished buffer is waiting to be read |
| rdy_ack | input | 1 | Host acknowledge; clears `buf_ready` |
| sync_err | output | 1 | Sticky flag for an early bunch-zero pulse |

## Verification
The hardest case to reach from the ports is a read-modify-write that hits the same bucket as the one just before it. With a realistic turn length this never happens. The bench reaches it by setting the turn length to one bucket and pulsing `bunch_zero` on every sample, so each update must use the result of the previous cycle's write instead of the stale bank output. Saturation needs more than 4096 turns at full scale. Again with a one-bucket turn, that takes only a few thousand clocks.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int unsigned SMP_W  = 12;
  localparam int unsigned SUM_W  = 24;
  localparam int unsigned HIT_W  = 12;
  localparam int unsigned WORD_W = SUM_W + HIT_W;

  typedef logic [SMP_W-1:0]  smp_t;
  typedef logic [WORD_W-1:0] word_t;

  // Merge one sample into a bucket word; 'first' starts a fresh buffer.
  function automatic word_t fold_word(word_t old, smp_t s, logic hit, logic first);
    logic [SUM_W:0]   sum_x;
    logic [SUM_W-1:0] sum_n;
    logic [HIT_W-1:0] cnt_o;
    logic [HIT_W-1:0] cnt_n;
    cnt_o = old[HIT_W-1:0];
    sum_x = {1'b0, old[WORD_W-1:HIT_W]} + (SUM_W+1)'(s);
    if (first) begin
      sum_n = SUM_W'(s);
      cnt_n = HIT_W'(hit);
    end else begin
      sum_n = sum_x[SUM_W] ? {SUM_W{1'b1}} : sum_x[SUM_W-1:0];
      cnt_n = (hit && (cnt_o != {HIT_W{1'b1}})) ? cnt_o + HIT_W'(1) : cnt_o;
    end
    return {sum_n, cnt_n};
  endfunction
endpackage

// File: rtl/tsa_bank.sv
module tsa_bank #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tsa_tracker.sv
module tsa_tracker
  import tsa_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned TURN_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  smp_t              adc_sample,
  input  logic              bunch_zero,
  input  smp_t              cfg_threshold,
  input  logic [ADDR_W:0]   cfg_turn_len,
  input  logic [TURN_W-1:0] cfg_turns_per_buf,
  input  logic [TURN_W-1:0] cfg_buf_period,
  output logic              s1_valid,
  output logic [ADDR_W-1:0] s1_addr,
  output smp_t              s1_smp,
  output logic              s1_hit,
  output logic              s1_first,
  output logic              s1_bank,
  output logic              acc_bank,
  output logic              swap_q,
  output logic              sync_err
);
  localparam int unsigned LEN_W = ADDR_W + 1;
  localparam logic [LEN_W-1:0]  ONE_L = LEN_W'(1);
  localparam logic [TURN_W-1:0] ONE_T = TURN_W'(1);

  logic              locked_q;
  logic [LEN_W-1:0]  idx_q, idx_n;
  logic [TURN_W-1:0] turn_q, turn_n, eff_period;
  logic              lock_n, swap_n, bank_n, err_n, valid_n;

  always_comb begin
    eff_period = (cfg_buf_period < cfg_turns_per_buf) ? cfg_turns_per_buf : cfg_buf_period;
    idx_n  = idx_q;
    turn_n = turn_q;
    lock_n = locked_q;
    swap_n = 1'b0;
    err_n  = 1'b0;
    if (bunch_zero) begin
      idx_n  = '0;
      lock_n = 1'b1;
      if (locked_q) begin
        swap_n = (turn_q == cfg_turns_per_buf - ONE_T);
        turn_n = (turn_q >= eff_period - ONE_T) ? '0 : turn_q + ONE_T;
        err_n  = ({1'b0, idx_q} + {1'b0, ONE_L}) < {1'b0, cfg_turn_len};
      end else begin
        turn_n = '0;
      end
    end else if (idx_q < cfg_turn_len) begin
      idx_n = idx_q + ONE_L;
    end
    bank_n  = acc_bank ^ swap_n;
    valid_n = lock_n && (turn_n < cfg_turns_per_buf) && (idx_n < cfg_turn_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      idx_q    <= '0;
      turn_q   <= '0;
      acc_bank <= 1'b0;
      swap_q   <= 1'b0;
      sync_err <= 1'b0;
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      s1_smp   <= '0;
      s1_hit   <= 1'b0;
      s1_first <= 1'b0;
      s1_bank  <= 1'b0;
    end else begin
      locked_q <= lock_n;
      idx_q    <= idx_n;
      turn_q   <= turn_n;
      acc_bank <= bank_n;
      swap_q   <= swap_n;
      sync_err <= sync_err | err_n;
      s1_valid <= valid_n;
      s1_addr  <= idx_n[ADDR_W-1:0];
      s1_smp   <= adc_sample;
      s1_hit   <= adc_sample > cfg_threshold;
      s1_first <= (turn_n == '0);
      s1_bank  <= bank_n;
    end
  end
endmodule

// File: rtl/tsa_rmw.sv
module tsa_rmw
  import tsa_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic [ADDR_W-1:0] s1_addr,
  input  smp_t              s1_smp,
  input  logic              s1_hit,
  input  logic              s1_first,
  input  logic              s1_bank,
  input  word_t             rd_bank0,
  input  word_t             rd_bank1,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [ADDR_W-1:0] wr_addr,
  output word_t             wr_data
);
  logic              s2_valid, s2_hit, s2_first, s2_bank;
  logic [ADDR_W-1:0] s2_addr;
  smp_t              s2_smp;
  logic              w_valid_q, w_bank_q;
  logic [ADDR_W-1:0] w_addr_q;
  word_t             w_data_q;
  word_t             old_word;
  logic              fwd;

  always_comb begin
    fwd      = w_valid_q && (w_addr_q == s2_addr) && (w_bank_q == s2_bank);
    old_word = fwd ? w_data_q : (s2_bank ? rd_bank1 : rd_bank0);
    wr_en    = s2_valid;
    wr_bank  = s2_bank;
    wr_addr  = s2_addr;
    wr_data  = fold_word(old_word, s2_smp, s2_hit, s2_first);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid  <= 1'b0;
      s2_addr   <= '0;
      s2_smp    <= '0;
      s2_hit    <= 1'b0;
      s2_first  <= 1'b0;
      s2_bank   <= 1'b0;
      w_valid_q <= 1'b0;
      w_bank_q  <= 1'b0;
      w_addr_q  <= '0;
      w_data_q  <= '0;
    end else begin
      s2_valid  <= s1_valid;
      s2_addr   <= s1_addr;
      s2_smp    <= s1_smp;
      s2_hit    <= s1_hit;
      s2_first  <= s1_first;
      s2_bank   <= s1_bank;
      w_valid_q <= wr_en;
      w_bank_q  <= wr_bank;
      w_addr_q  <= wr_addr;
      w_data_q  <= wr_data;
    end
  end
endmodule

// File: rtl/turn_stack_acc.sv
module turn_stack_acc
  import tsa_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned TURN_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SMP_W-1:0]  adc_sample,
  input  logic              bunch_zero,
  input  logic [SMP_W-1:0]  cfg_threshold,
  input  logic [ADDR_W:0]   cfg_turn_len,
  input  logic [TURN_W-1:0] cfg_turns_per_buf,
  input  logic [TURN_W-1:0] cfg_buf_period,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              buf_ready,
  input  logic              rdy_ack,
  output logic              sync_err
);
  localparam int unsigned NBANK = 2;

  logic              s1_valid, s1_hit, s1_first, s1_bank, acc_bank, swap_q;
  logic [ADDR_W-1:0] s1_addr;
  smp_t              s1_smp;
  logic              wr_en, wr_bank;
  logic [ADDR_W-1:0] wr_addr;
  word_t             wr_data;
  word_t             bank_rd [NBANK];
  logic              host_bank_q;

  tsa_tracker #(.ADDR_W(ADDR_W), .TURN_W(TURN_W)) u_trk (
    .clk, .rst, .adc_sample, .bunch_zero, .cfg_threshold, .cfg_turn_len,
    .cfg_turns_per_buf, .cfg_buf_period,
    .s1_valid, .s1_addr, .s1_smp, .s1_hit, .s1_first, .s1_bank,
    .acc_bank, .swap_q, .sync_err
  );

  tsa_rmw #(.ADDR_W(ADDR_W)) u_rmw (
    .clk, .rst, .s1_valid, .s1_addr, .s1_smp, .s1_hit, .s1_first, .s1_bank,
    .rd_bank0(bank_rd[0]), .rd_bank1(bank_rd[1]),
    .wr_en, .wr_bank, .wr_addr, .wr_data
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic              b_we;
    logic [ADDR_W-1:0] b_raddr;
    assign b_we    = wr_en && (wr_bank == 1'(b));
    assign b_raddr = (s1_valid && (s1_bank == 1'(b))) ? s1_addr : rd_addr;
    tsa_bank #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_bank (
      .clk, .we(b_we), .waddr(wr_addr), .wdata(wr_data),
      .raddr(b_raddr), .rdata(bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_bank_q <= 1'b1;
      rd_data     <= '0;
      buf_ready   <= 1'b0;
    end else begin
      host_bank_q <= ~acc_bank;
      rd_data     <= bank_rd[host_bank_q];
      if (swap_q)       buf_ready <= 1'b1;
      else if (rdy_ack) buf_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/tsa_checker.sv
module tsa_checker (
  input logic clk,
  input logic rst,
  input logic bunch_zero,
  input logic rdy_ack,
  input logic buf_ready,
  input logic sync_err
);
  p_ready_after_bz_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_ready) |-> $past(bunch_zero, 2));

  p_ready_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (buf_ready && !rdy_ack) |=> buf_ready);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (buf_ready && rdy_ack && !$past(bunch_zero)) |=> !buf_ready);

  p_sync_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    sync_err |=> sync_err);

  p_sync_on_bz_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_err) |-> $past(bunch_zero));
endmodule

bind turn_stack_acc tsa_checker u_chk (
  .clk(clk), .rst(rst), .bunch_zero(bunch_zero), .rdy_ack(rdy_ack),
  .buf_ready(buf_ready), .sync_err(sync_err)
);

// File: tb/turn_stack_acc_tb.sv
module turn_stack_acc_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] adc_sample;
  logic        bunch_zero;
  logic [11:0] cfg_threshold;
  logic [12:0] cfg_turn_len;
  logic [12:0] cfg_turns_per_buf;
  logic [12:0] cfg_buf_period;
  logic [11:0] rd_addr;
  logic [35:0] rd_data;
  logic        buf_ready, rdy_ack, sync_err;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  turn_stack_acc u_dut (
    .clk, .rst, .adc_sample, .bunch_zero, .cfg_threshold, .cfg_turn_len,
    .cfg_turns_per_buf, .cfg_buf_period, .rd_addr, .rd_data,
    .buf_ready, .rdy_ack, .sync_err
  );

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic feed(int s, bit b);
    adc_sample = 12'(s);
    bunch_zero = b;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) feed(0, 1'b0);
  endtask

  task automatic setup(int len, int nt, int per, int thr);
    rst = 1'b1; rdy_ack = 1'b0; bunch_zero = 1'b0; adc_sample = '0; rd_addr = '0;
    cfg_turn_len = 13'(len); cfg_turns_per_buf = 13'(nt);
    cfg_buf_period = 13'(per); cfg_threshold = 12'(thr);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack();
    rdy_ack = 1'b1;
    @(negedge clk);
    rdy_ack = 1'b0;
  endtask

  // rd_data follows rd_addr after two clock edges
  task automatic expect_word(string req, int addr, int sum, int cnt);
    rd_addr = 12'(addr);
    repeat (2) @(negedge clk);
    check({req, " sum"}, longint'(rd_data[35:12]), longint'(sum));
    check({req, " count"}, longint'(rd_data[11:0]), longint'(cnt));
  endtask

  task automatic t_reset();
    setup(4, 2, 2, 100);
    check("R1 buf_ready after reset", buf_ready, 0);
    check("R1 sync_err after reset", sync_err, 0);
  endtask

  task automatic t_basic_stack();
    setup(4, 2, 2, 100);
    feed(10, 1); feed(200, 0); feed(50, 0); feed(4095, 0);
    feed(20, 1); feed(150, 0); feed(101, 0); feed(100, 0);
    check("R5 not ready before closing pulse", buf_ready, 0);
    feed(0, 1);
    idle(3);
    check("R5 ready after swap", buf_ready, 1);
    check("R8 no sync error on full turns", sync_err, 0);
    expect_word("R2 bucket3 R3 equal not hit", 3, 4195, 1);
    expect_word("R2 bucket0", 0, 30, 0);
    expect_word("R2 bucket1", 1, 350, 2);
    expect_word("R3 bucket2 just above", 2, 151, 1);
    idle(3);
    check("R6 ready held without ack", buf_ready, 1);
    ack();
    check("R6 ack clears ready", buf_ready, 0);
  endtask

  task automatic t_overwrite();
    setup(2, 1, 1, 4095);
    feed(1, 1); feed(2, 0);
    feed(3, 1); feed(4, 0);
    idle(3);
    expect_word("R4 first buffer b0", 0, 1, 0);
    ack();
    feed(5, 1); feed(6, 0);
    idle(3);
    expect_word("R4 second buffer b1", 1, 4, 0);
    ack();
    feed(0, 1);
    idle(3);
    check("R5 third ready", buf_ready, 1);
    expect_word("R4 reused bank b0", 0, 5, 0);
    expect_word("R4 reused bank b1", 1, 6, 0);
  endtask

  task automatic t_schedule();
    setup(2, 1, 3, 0);
    feed(10, 1); feed(11, 0);
    feed(20, 1); feed(21, 0);
    feed(30, 1); feed(31, 0);
    idle(2);
    expect_word("R7 active turn b0", 0, 10, 1);
    expect_word("R7 active turn b1", 1, 11, 1);
    ack();
    feed(40, 1); feed(41, 0);
    idle(2);
    check("R7 idle turns cause no swap", buf_ready, 0);
    feed(0, 1);
    idle(3);
    check("R7 swap after next start", buf_ready, 1);
    expect_word("R7 idle turns not stored b0", 0, 40, 1);
    expect_word("R7 idle turns not stored b1", 1, 41, 1);
  endtask

  task automatic t_sync();
    setup(4, 1, 1, 0);
    feed(5, 1); feed(6, 0);
    feed(7, 1); feed(8, 0); feed(9, 0); feed(10, 0);
    idle(3);
    check("R8 early pulse flags", sync_err, 1);
    expect_word("R8 short turn b0", 0, 5, 1);
    expect_word("R8 short turn b1", 1, 6, 1);
    ack();
    feed(0, 1);
    idle(3);
    expect_word("R8 restart b0", 0, 7, 1);
    expect_word("R8 restart b3", 3, 10, 1);
    check("R8 flag sticky", sync_err, 1);
  endtask

  task automatic t_overrun();
    setup(2, 1, 1, 4095);
    feed(1, 1); feed(2, 0); feed(3, 0); feed(4, 0);
    feed(0, 1);
    idle(3);
    check("R9 late pulse no error", sync_err, 0);
    expect_word("R9 extra samples dropped b0", 0, 1, 0);
    expect_word("R9 extra samples dropped b1", 1, 2, 0);
  endtask

  task automatic t_back_to_back();
    setup(1, 3, 3, 150);
    feed(100, 1); feed(200, 1); feed(300, 1);
    feed(0, 1);
    idle(3);
    check("R10 no sync error at length 1", sync_err, 0);
    expect_word("R10 same bucket chain", 0, 600, 2);
  endtask

  task automatic t_saturate();
    setup(1, 4100, 4100, 0);
    for (int i = 0; i < 4100; i++) feed(4095, 1);
    feed(0, 1);
    idle(3);
    expect_word("R11 saturation", 0, 16777215, 4095);
  endtask

  initial begin
    t_reset();
    t_basic_stack();
    t_overwrite();
    t_schedule();
    t_sync();
    t_overrun();
    t_back_to_back();
    t_saturate();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule